// File: doc/BRIEF.md
# Dual-Read Shared-Bitline Register File

This block is a small register file whose rows each hold one word in a differential cell pair. Every row has two word selects: one couples the row onto the true-polarity bit lines, the other onto the complement-polarity bit lines. Because the two read ports ride on the two polarities of the same bit-line pair, a cycle can serve two reads or one write, but never both.

In a read cycle, port A senses the complement side and re-inverts it, so both ports deliver true data. Port B senses the true side. The two addresses may name different rows or the same row. A write needs both polarities of one row, so only one word can be written per cycle.

If a read is requested while the mode selects a write, the read is dropped and an error flag is raised. Read results are registered. They appear one clock after the request and are held until the next served read.

Top module: `rf_dual_read`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stored word, both read outputs and `err` are cleared to zero.
- R2: With `wr_mode`=0 and `rd_en`=1, `rd_data_a` shows, after the next rising edge, the true value of the word at `rd_addr_a`. That value is sensed on the complement side and inverted back.
- R3: With `wr_mode`=0 and `rd_en`=1, `rd_data_b` shows, after the next rising edge, the word at `rd_addr_b`, sensed on the true side.
- R4: Two different rows are read in the same cycle, each port returning its own row.
- R5: When `rd_addr_a` equals `rd_addr_b` in a read cycle, both outputs return the same word.
- R6: With `wr_mode`=1, `wr_data` is stored at `wr_addr` on the rising edge, and exactly one row changes per cycle.
- R7: Both read outputs keep their previous values after any cycle that is not a served read. This covers write cycles and cycles with `wr_mode`=0 and `rd_en`=0.
- R8: With `wr_mode`=1 and `rd_en`=1, the read is ignored, so the outputs hold. The write is still performed, and `err` is 1 for the one cycle after that edge.
- R9: `err` is 0 after any edge where `wr_mode` and `rd_en` were not both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_mode | input | 1 | 1 = write cycle, 0 = read-pair cycle |
| rd_en | input | 1 | Read request |
| rd_addr_a | input | 4 | Row for port A (complement side) |
| rd_addr_b | input | 4 | Row for port B (true side) |
| wr_addr | input | 4 | Row to write |
| wr_data | input | 8 | Word to write |
| rd_data_a | output | 8 | Registered true data for port A |
| rd_data_b | output | 8 | Registered data for port B |
| err | output | 1 | Read requested during a write cycle |

## Verification
The bench first fills every row with an arithmetic pattern and then reads all 256 ordered address pairs. This distinguishes a missing re-inversion on port A, crossed ports and address decoding faults. The diagonal of the sweep covers the case where both ports select the same row.

Writes are issued with the read request alternately on and off. This separates a correctly flagged and ignored conflict from one that leaks read data or suppresses the write. Idle cycles, a second pattern of inverted words, and a mid-run reset show that outputs hold outside served reads and that reset clears the stored contents.

// File: rtl/rf_pkg.sv
// Package: shared cycle-mode encoding for the dual-read register file.
// Assumes a single-bit mode input where 1 selects a write cycle.
package rf_pkg;
    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } rf_mode_e;
endpackage

// File: rtl/rf_mode_ctrl.sv
// Module: rf_mode_ctrl
// Decodes the cycle mode and read request into a served write, a served read
// and a conflict indication. Assumes the mode input is valid every cycle.
module rf_mode_ctrl
    import rf_pkg::*;
(
    input  logic wr_mode,
    input  logic rd_en,
    output logic do_write,
    output logic do_read,
    output logic conflict
);
    rf_mode_e mode;

    // Classify the cycle: a write always wins the shared bit lines.
    always_comb begin
        mode     = rf_mode_e'(wr_mode);
        do_write = (mode == MODE_WRITE);
        do_read  = (mode == MODE_READ) && rd_en;
        conflict = (mode == MODE_WRITE) && rd_en;
    end
endmodule

// File: rtl/rf_cell_array.sv
// Module: rf_cell_array
// Row storage with two word selects per row. The complement select drives the
// inverted word onto the complement bit lines; the true select drives the word
// onto the true bit lines. A write asserts both selects of one row.
// Assumes do_write and do_read are never both high.
module rf_cell_array #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_write,
    input  logic             do_read,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    sel_addr_comp,
    input  logic [AW-1:0]    sel_addr_true,
    output logic [WIDTH-1:0] bl_comp,
    output logic [WIDTH-1:0] bl_true
);
    logic [DEPTH-1:0] wsel_comp;
    logic [DEPTH-1:0] wsel_true;
    logic [WIDTH-1:0] row_val [DEPTH];

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        logic [WIDTH-1:0] cell_q;

        // Word-select decode for this row on each polarity.
        always_comb begin
            if (do_write) begin
                wsel_comp[r] = (wr_addr == AW'(r));
                wsel_true[r] = (wr_addr == AW'(r));
            end else begin
                wsel_comp[r] = do_read && (sel_addr_comp == AW'(r));
                wsel_true[r] = do_read && (sel_addr_true == AW'(r));
            end
        end

        // Cell update: needs both polarities selected during a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (do_write && wsel_comp[r] && wsel_true[r])
                cell_q <= wr_data;
        end

        assign row_val[r] = cell_q;
    end

    // Bit-line evaluation: selected rows pull their polarity onto the lines.
    always_comb begin
        bl_comp = '0;
        bl_true = '0;
        for (int r = 0; r < DEPTH; r++) begin
            if (wsel_comp[r]) bl_comp = bl_comp | ~row_val[r];
            if (wsel_true[r]) bl_true = bl_true | row_val[r];
        end
    end
endmodule

// File: rtl/rf_read_stage.sv
// Module: rf_read_stage
// Registers both read ports and the conflict flag. Port A re-inverts the
// complement bit lines. Outputs only load on a served read.
module rf_read_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_read,
    input  logic             conflict,
    input  logic [WIDTH-1:0] bl_comp,
    input  logic [WIDTH-1:0] bl_true,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    output logic             err
);
    // Capture sensed data on served reads, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_a <= '0;
            rd_data_b <= '0;
        end else if (do_read) begin
            rd_data_a <= ~bl_comp;
            rd_data_b <= bl_true;
        end
    end

    // One-cycle error flag for a read requested during a write.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= conflict;
    end
endmodule

// File: rtl/rf_dual_read.sv
// Module: rf_dual_read (top)
// Register file whose two read ports share the differential bit-line pair:
// one cycle serves two reads or one write. Assumes synchronous active-low reset.
module rf_dual_read #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    output logic             err
);
    logic             do_write;
    logic             do_read;
    logic             conflict;
    logic [WIDTH-1:0] bl_comp;
    logic [WIDTH-1:0] bl_true;

    rf_mode_ctrl u_ctrl (
        .wr_mode  (wr_mode),
        .rd_en    (rd_en),
        .do_write (do_write),
        .do_read  (do_read),
        .conflict (conflict)
    );

    rf_cell_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk           (clk),
        .rst_n         (rst_n),
        .do_write      (do_write),
        .do_read       (do_read),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .sel_addr_comp (rd_addr_a),
        .sel_addr_true (rd_addr_b),
        .bl_comp       (bl_comp),
        .bl_true       (bl_true)
    );

    rf_read_stage #(.WIDTH(WIDTH)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_read   (do_read),
        .conflict  (conflict),
        .bl_comp   (bl_comp),
        .bl_true   (bl_true),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .err       (err)
    );
endmodule

// File: rtl/rf_dual_read_checker.sv
// Module: rf_dual_read_checker
// Port-level properties of the dual-read register file, bound to the top.
module rf_dual_read_checker #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_mode,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr_a,
    input logic [AW-1:0]    rd_addr_b,
    input logic [WIDTH-1:0] rd_data_a,
    input logic [WIDTH-1:0] rd_data_b,
    input logic             err
);
    // R1: reset clears outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data_a == '0 && rd_data_b == '0 && !err));

    // R5: same row on both ports gives identical data
    p_same_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mode && rd_en && rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

    // R7: outputs hold when no read is served
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode || !rd_en) |=> ($stable(rd_data_a) && $stable(rd_data_b)));

    // R8: conflict raises the flag
    p_conflict_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && rd_en) |=> err);

    // R9: no conflict, no flag
    p_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_mode && rd_en) |=> !err);
endmodule

bind rf_dual_read rf_dual_read_checker #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .rd_en     (rd_en),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .err       (err)
);

// File: tb/tb_rf_dual_read.sv
module tb_rf_dual_read;
    localparam int WIDTH = 8;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_mode;
    logic             rd_en;
    logic [AW-1:0]    rd_addr_a;
    logic [AW-1:0]    rd_addr_b;
    logic [AW-1:0]    wr_addr;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] rd_data_a;
    logic [WIDTH-1:0] rd_data_b;
    logic             err;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic done = 1'b0;

    rf_dual_read dut (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .rd_en(rd_en),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .err(err)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input int i, input bit inv);
        logic [7:0] v;
        v = 8'((i * 37 + 5) & 8'hFF);
        return inv ? ~v : v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs at a negedge, let one posedge pass, return at next negedge.
    task automatic step(input logic rn, input logic wm, input logic re,
                        input int a, input int b, input int wa, input logic [7:0] wd);
        rst_n = rn; wr_mode = wm; rd_en = re;
        rd_addr_a = AW'(a); rd_addr_b = AW'(b); wr_addr = AW'(wa); wr_data = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(input bit inv);
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < DEPTH; b++) begin
                step(1, 0, 1, a, b, 0, 8'h00);
                chk("R2", rd_data_a, pat(a, inv));
                chk(a == b ? "R5" : "R4", rd_data_b, pat(b, inv));
                if (a == b) chk("R5", rd_data_a, rd_data_b);
                chk("R9", err, 0);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 0, 0, 0, 8'h00);
        chk("R1", rd_data_a, 0);
        chk("R1", rd_data_b, 0);
        chk("R1", err, 0);
        step(1, 0, 1, 3, 9, 0, 8'h00);
        chk("R1", rd_data_a, 0);
        chk("R3", rd_data_b, 0);
        // Fill rows; odd rows carry a conflicting read request.
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] ha, hb;
            ha = rd_data_a; hb = rd_data_b;
            step(1, 1, logic'(i % 2), i, (i + 1) % DEPTH, i, pat(i, 0));
            chk("R7", rd_data_a, ha);
            chk("R7", rd_data_b, hb);
            chk(i % 2 ? "R8" : "R9", err, logic'(i % 2));
        end
        // Flag lasts one cycle only.
        step(1, 0, 0, 0, 0, 0, 8'h00);
        chk("R9", err, 0);
        // Conflict write must still land (R8) and R6 one row only.
        sweep(0);
        step(1, 0, 0, 5, 6, 0, 8'h00);
        chk("R7", rd_data_a, pat(DEPTH - 1, 0));
        chk("R7", rd_data_b, pat(DEPTH - 1, 0));
        for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 0, 0, i, pat(i, 1));
        sweep(1);
        // R6: single write changes exactly one row.
        step(1, 1, 0, 0, 0, 7, 8'h5A);
        for (int r = 0; r < DEPTH; r++) begin
            step(1, 0, 1, r, r, 0, 8'h00);
            chk("R6", rd_data_a, r == 7 ? 8'h5A : pat(r, 1));
        end
        // R1: mid-run reset clears stored words.
        step(0, 0, 0, 0, 0, 0, 8'h00);
        for (int r = 0; r < DEPTH; r += 5) begin
            step(1, 0, 1, r, DEPTH - 1 - r, 0, 8'h00);
            chk("R1", rd_data_a, 0);
            chk("R1", rd_data_b, 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule